// File: doc/BRIEF.md
# Transaction Packet Transmit Beat Packer

This block turns one outbound transaction packet request into a sequence of beats on a 64-bit streaming transmit bus. A request carries a four-dword header, a start address and a payload length. The payload dwords are pushed beforehand or alongside into a small internal buffer. The block emits two header beats and then the payload beats. It places each dword on the lower lane (bits 31:0) or the upper lane (bits 63:32) of the bus. The placement depends on whether the start address falls on an eight-byte boundary.

The sink controls flow with a ready signal that takes effect two cycles late. A beat is transferred in any cycle where valid is high, because the block raises valid only when the ready value sampled two clock edges earlier was high. Packet boundaries are shown by start and end markers. An error output exists on the bus and is always driven low. A new request is taken only once the final beat of the previous packet has been transferred.

Top module: `tlp_tx_packer`

## Requirements
- R1: The first beat of every packet carries header dword 0 (req_hdr[31:0]) in the lower lane and header dword 1 (req_hdr[63:32]) in the upper lane. The second beat carries header dword 2 in the lower lane and header dword 3 in the upper lane.
- R2: When req_addr bit 2 is 0, payload dword 0 is in the lower lane of the first payload beat. Each later pair of dwords follows, with the even-indexed dword in the lower lane and the odd-indexed dword in the upper lane.
- R3: When req_addr bit 2 is 1, the first payload beat has payload dword 0 in the upper lane and zero in the lower lane. Dwords 1 and 2 then fill the lower and upper lanes of the next beat, and the pairing continues the same way.
- R4: A final beat that holds a single payload dword carries it in the lower lane, with zero in the upper lane.
- R5: tx_sop is high only on the first header beat. tx_eop is high only on the beat holding the last payload dword. With a payload length of 0, tx_eop is on the second header beat.
- R6: tx_valid is high only if tx_ready was high at the clock edge two edges before the current cycle. After ready falls, at most two more valid beats appear.
- R7: While a beat is waiting and not transferred, tx_data, tx_sop and tx_eop hold their values. Valid returns in the second cycle after ready is seen high again.
- R8: Every beat of a packet appears exactly once, in order, across any pattern of ready pauses and payload buffer starvation.
- R9: req_ready is high only when no packet is in progress. It stays low from the clock edge that accepts a request until the edge that transfers that packet's end beat.
- R10: tx_err is low at all times.
- R11: pl_full is high exactly when the payload buffer holds BUF_DEPTH dwords. A push while it is high is discarded. Payload dwords leave the buffer in push order.
- R12: After reset, tx_valid is low, req_ready is high, pl_full is low and tx_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A packet request is offered |
| req_ready | output | 1 | The block is idle and accepts a request |
| req_addr | input | ADDR_W | Start address; bit 2 selects the lane alignment |
| req_len | input | LEN_W | Payload length in dwords, 0 to MAX_LEN |
| req_hdr | input | 128 | Four header dwords; dword k is bits 32k+31:32k |
| pl_push | input | 1 | Write one payload dword into the buffer |
| pl_data | input | 32 | Payload dword being pushed |
| pl_full | output | 1 | Payload buffer is full |
| tx_ready | input | 1 | Sink ready; acts two cycles late |
| tx_valid | output | 1 | Current beat is transferred this cycle |
| tx_sop | output | 1 | Beat is the first of a packet |
| tx_eop | output | 1 | Beat is the last of a packet |
| tx_err | output | 1 | Error marker, always low |
| tx_data | output | 64 | Beat data, upper lane 63:32, lower lane 31:0 |

## Verification
The bench builds the block with MAX_LEN 256, READY_LAT 2 and a payload buffer only four dwords deep. The shallow buffer means long packets regularly drain it. This produces gaps in which no beat is waiting, and it lets the buffer be filled to its limit before a request. It also allows an extra push against a full buffer to be seen, through the contents of the following packet. With the full length range, a 256-dword aligned packet and a 255-dword unaligned packet are reachable. Ready patterns of single-cycle toggles and longer low stretches exercise both the two-beat overrun after ready falls and the two-cycle resume.

// File: rtl/tlp_pack_pkg.sv
package tlp_pack_pkg;

  localparam int DWORD_W = 32;
  localparam int BEAT_W  = 2 * DWORD_W;
  localparam int HDR_DW  = 4;

  typedef enum logic [1:0] {
    FMT_IDLE  = 2'd0,
    FMT_HDR_A = 2'd1,
    FMT_HDR_B = 2'd2,
    FMT_DATA  = 2'd3
  } fmt_state_e;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic              sop;
    logic              eop;
  } beat_t;

endpackage

// File: rtl/pl_fifo.sv
module pl_fifo #(
  parameter  int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [31:0]  push_data,
  output logic         full,
  input  logic [1:0]   pop_cnt,
  output logic [31:0]  head0,
  output logic [31:0]  head1,
  output logic [CNT_W-1:0] count
);

  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_nxt;
  logic [PTR_W-1:0] rd_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0] count_nxt;
  logic             push_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;

  always_comb begin
    wr_ptr_nxt = wr_ptr + PTR_W'(push_ok);
    rd_ptr_nxt = rd_ptr + PTR_W'(pop_cnt);
    count_nxt  = count + CNT_W'(push_ok) - CNT_W'(pop_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= push_data;
    end
  end

  assign head0 = mem[rd_ptr];
  assign head1 = mem[rd_ptr + PTR_W'(1)];

endmodule

// File: rtl/ready_delay.sv
module ready_delay #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_in,
  output logic rdy_out
);

  generate
    if (LAT == 0) begin : g_direct
      assign rdy_out = rdy_in;
    end else if (LAT == 1) begin : g_one
      logic stage_q, stage_n;
      assign stage_n = rdy_in;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= stage_n;
      end
      assign rdy_out = stage_q;
    end else begin : g_chain
      logic [LAT-1:0] stage_q, stage_n;
      assign stage_n = {stage_q[LAT-2:0], rdy_in};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_n;
      end
      assign rdy_out = stage_q[LAT-1];
    end
  endgenerate

endmodule

// File: rtl/tx_beat_slot.sv
module tx_beat_slot
  import tlp_pack_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t beat_in,
  input  logic  fire,
  output beat_t beat_q,
  output logic  full_q
);

  beat_t beat_n;
  logic  full_n;

  always_comb begin
    beat_n = beat_q;
    full_n = full_q;
    if (fire) begin
      full_n = 1'b0;
    end
    if (load) begin
      beat_n = beat_in;
      full_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      full_q <= 1'b0;
    end else begin
      beat_q <= beat_n;
      full_q <= full_n;
    end
  end

endmodule

// File: rtl/beat_former.sv
module beat_former
  import tlp_pack_pkg::*;
#(
  parameter  int MAX_LEN = 256,
  parameter  int CNT_W   = 4,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [127:0]     req_hdr,
  input  logic             req_misaligned,
  input  logic [LEN_W-1:0] req_len,
  input  logic             slot_busy,
  input  logic             slot_free,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic [31:0]      head0,
  input  logic [31:0]      head1,
  output logic             load_beat,
  output beat_t            beat_nxt,
  output logic [1:0]       pop_cnt
);

  fmt_state_e       state_q, state_n;
  logic [127:0]     hdr_q, hdr_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             skew_q, skew_n;
  logic [1:0]       need;
  logic             have_data;
  logic             last_data;

  // dwords consumed by the next payload beat
  always_comb begin
    if (skew_q)                     need = 2'd1;
    else if (rem_q >= LEN_W'(2))    need = 2'd2;
    else                            need = 2'd1;
    have_data = (fifo_cnt >= CNT_W'(need));
    last_data = (rem_q == LEN_W'(need));
  end

  always_comb begin
    state_n   = state_q;
    hdr_n     = hdr_q;
    rem_n     = rem_q;
    skew_n    = skew_q;
    load_beat = 1'b0;
    pop_cnt   = 2'd0;
    beat_nxt  = '0;
    req_ready = (state_q == FMT_IDLE) && !slot_busy;

    unique case (state_q)
      FMT_IDLE: begin
        if (req_valid && req_ready) begin
          hdr_n   = req_hdr;
          rem_n   = req_len;
          skew_n  = req_misaligned;
          state_n = FMT_HDR_A;
        end
      end
      FMT_HDR_A: begin
        if (slot_free) begin
          load_beat         = 1'b1;
          beat_nxt.data     = {hdr_q[63:32], hdr_q[31:0]};
          beat_nxt.sop      = 1'b1;
          state_n           = FMT_HDR_B;
        end
      end
      FMT_HDR_B: begin
        if (slot_free) begin
          load_beat     = 1'b1;
          beat_nxt.data = {hdr_q[127:96], hdr_q[95:64]};
          beat_nxt.eop  = (rem_q == '0);
          state_n       = (rem_q == '0) ? FMT_IDLE : FMT_DATA;
        end
      end
      FMT_DATA: begin
        if (slot_free && have_data) begin
          load_beat = 1'b1;
          pop_cnt   = need;
          if (skew_q)              beat_nxt.data = {head0, 32'h0};
          else if (need == 2'd2)   beat_nxt.data = {head1, head0};
          else                     beat_nxt.data = {32'h0, head0};
          beat_nxt.eop = last_data;
          rem_n        = rem_q - LEN_W'(need);
          skew_n       = 1'b0;
          if (last_data) begin
            state_n = FMT_IDLE;
          end
        end
      end
      default: state_n = FMT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FMT_IDLE;
      hdr_q   <= '0;
      rem_q   <= '0;
      skew_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      hdr_q   <= hdr_n;
      rem_q   <= rem_n;
      skew_q  <= skew_n;
    end
  end

endmodule

// File: rtl/tlp_tx_packer.sv
module tlp_tx_packer
  import tlp_pack_pkg::*;
#(
  parameter  int MAX_LEN   = 256,
  parameter  int BUF_DEPTH = 8,
  parameter  int READY_LAT = 2,
  parameter  int ADDR_W    = 64,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CNT_W     = $clog2(BUF_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [127:0]      req_hdr,
  input  logic              pl_push,
  input  logic [31:0]       pl_data,
  output logic              pl_full,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              tx_err,
  output logic [63:0]       tx_data
);

  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic             rdy_late;
  logic [CNT_W-1:0] fifo_cnt;
  logic [31:0]      head0, head1;
  logic [1:0]       pop_cnt;
  logic             load_beat;
  beat_t            beat_nxt, beat_q;
  logic             beat_full;
  logic             fire;
  logic             slot_free;
  logic             unused_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  assign unused_addr = ^{req_addr[ADDR_W-1:3], req_addr[1:0]};

  ready_delay #(.LAT(READY_LAT)) u_rdy (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rdy_in (tx_ready),
    .rdy_out(rdy_late)
  );

  pl_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (pl_push),
    .push_data(pl_data),
    .full     (pl_full),
    .pop_cnt  (pop_cnt),
    .head0    (head0),
    .head1    (head1),
    .count    (fifo_cnt)
  );

  assign fire      = beat_full && rdy_late;
  assign slot_free = !beat_full || fire;

  beat_former #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_fmt (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_hdr       (req_hdr),
    .req_misaligned(req_addr[2]),
    .req_len       (req_len),
    .slot_busy     (beat_full),
    .slot_free     (slot_free),
    .fifo_cnt      (fifo_cnt),
    .head0         (head0),
    .head1         (head1),
    .load_beat     (load_beat),
    .beat_nxt      (beat_nxt),
    .pop_cnt       (pop_cnt)
  );

  tx_beat_slot u_slot (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load   (load_beat),
    .beat_in(beat_nxt),
    .fire   (fire),
    .beat_q (beat_q),
    .full_q (beat_full)
  );

  assign tx_valid = fire;
  assign tx_sop   = beat_q.sop;
  assign tx_eop   = beat_q.eop;
  assign tx_data  = beat_q.data;
  assign tx_err   = 1'b0;

endmodule

// File: rtl/tlp_tx_packer_chk.sv
module tlp_tx_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_ready,
  input logic        tx_valid,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        tx_err,
  input logic [63:0] tx_data,
  input logic        req_ready,
  input logic        beat_full
);

  logic seen1_q, seen2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen1_q <= 1'b0;
      seen2_q <= 1'b0;
    end else begin
      seen1_q <= tx_ready;
      seen2_q <= seen1_q;
    end
  end

  AST_VALID_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> seen2_q); // R6

  AST_HOLD_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_full && !tx_valid) |=> ($stable(tx_data) && $stable(tx_sop) && $stable(tx_eop))); // R7

  AST_RESUME_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_full && seen2_q && $past(beat_full)) |-> tx_valid); // R7

  AST_SOP_NOT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> !tx_eop); // R5

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> !req_ready); // R9

  AST_ERR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_err); // R10

endmodule

bind tlp_tx_packer tlp_tx_packer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_ready (tx_ready),
  .tx_valid (tx_valid),
  .tx_sop   (tx_sop),
  .tx_eop   (tx_eop),
  .tx_err   (tx_err),
  .tx_data  (tx_data),
  .req_ready(req_ready),
  .beat_full(beat_full)
);

// File: tb/tlp_tx_packer_test.sv
`timescale 1ns/1ps
module tlp_tx_packer_test;

  localparam int MAX_LEN   = 256;
  localparam int BUF_DEPTH = 4;
  localparam int READY_LAT = 2;
  localparam int ADDR_W    = 64;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam int EXP_MAX   = 140;
  localparam int NVEC      = 12;

  typedef struct packed {
    logic [8:0] len;
    logic       skew;
    logic [2:0] mode;
  } vec_t;

  // payload length, unaligned start, ready pattern
  localparam vec_t VECS [NVEC] = '{
    '{9'd0,   1'b0, 3'd0},
    '{9'd1,   1'b0, 3'd0},
    '{9'd1,   1'b1, 3'd0},
    '{9'd2,   1'b0, 3'd0},
    '{9'd2,   1'b1, 3'd0},
    '{9'd3,   1'b0, 3'd1},
    '{9'd3,   1'b1, 3'd1},
    '{9'd6,   1'b0, 3'd2},
    '{9'd7,   1'b1, 3'd2},
    '{9'd13,  1'b1, 3'd3},
    '{9'd256, 1'b0, 3'd1},
    '{9'd255, 1'b1, 3'd0}
  };

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [127:0]      req_hdr;
  logic              pl_push;
  logic [31:0]       pl_data;
  logic              pl_full;
  logic              tx_ready;
  logic              tx_valid;
  logic              tx_sop;
  logic              tx_eop;
  logic              tx_err;
  logic [63:0]       tx_data;

  tlp_tx_packer #(
    .MAX_LEN(MAX_LEN), .BUF_DEPTH(BUF_DEPTH), .READY_LAT(READY_LAT), .ADDR_W(ADDR_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_hdr(req_hdr),
    .pl_push(pl_push), .pl_data(pl_data), .pl_full(pl_full),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_err(tx_err), .tx_data(tx_data)
  );

  int checks;
  int fails;
  int cyc;
  int rdy_mode;
  logic [63:0] exp_data [EXP_MAX];
  logic        exp_sop  [EXP_MAX];
  logic        exp_eop  [EXP_MAX];
  int          exp_n;
  int          mon_idx;
  logic        in_flight;
  logic        mon_on;
  logic        r1, r2;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] hdr_dw(input int tag, input int k);
    return {8'(tag), 8'(8'hC0 + k), 16'h1234};
  endfunction

  function automatic logic [31:0] pay_dw(input int tag, input int i);
    return {8'(tag), 8'h5A, 16'(i)};
  endfunction

  task automatic build_exp(input int tag, input logic skew, input int len);
    int i;
    exp_n = 0;
    exp_data[0] = {hdr_dw(tag, 1), hdr_dw(tag, 0)}; exp_sop[0] = 1'b1; exp_eop[0] = 1'b0;
    exp_data[1] = {hdr_dw(tag, 3), hdr_dw(tag, 2)}; exp_sop[1] = 1'b0; exp_eop[1] = 1'b0;
    exp_n = 2;
    i = 0;
    if (skew && len > 0) begin
      exp_data[exp_n] = {pay_dw(tag, 0), 32'h0}; exp_sop[exp_n] = 1'b0; exp_eop[exp_n] = 1'b0;
      exp_n++; i = 1;
    end
    while (i < len) begin
      if (len - i >= 2) begin
        exp_data[exp_n] = {pay_dw(tag, i + 1), pay_dw(tag, i)}; i += 2;
      end else begin
        exp_data[exp_n] = {32'h0, pay_dw(tag, i)}; i += 1;
      end
      exp_sop[exp_n] = 1'b0; exp_eop[exp_n] = 1'b0;
      exp_n++;
    end
    exp_eop[exp_n-1] = 1'b1;
    mon_idx = 0;
  endtask

  task automatic push_all(input int tag, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (pl_full) begin
        pl_push = 1'b0;
        @(negedge clk);
      end
      pl_push = 1'b1;
      pl_data = pay_dw(tag, i);
    end
    @(negedge clk);
    pl_push = 1'b0;
  endtask

  task automatic issue_req(input int tag, input logic skew, input int len);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 64'h0000_0000_0000_1000 | (64'(skew) << 2);
    req_len   = LEN_W'(len);
    req_hdr   = {hdr_dw(tag, 3), hdr_dw(tag, 2), hdr_dw(tag, 1), hdr_dw(tag, 0)};
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_flight = 1'b1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (mon_idx < exp_n) @(negedge clk);
    @(negedge clk);
  endtask

  // ready pattern driver
  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (rdy_mode)
      0: tx_ready <= 1'b1;
      1: tx_ready <= ((cyc % 7) >= 3);
      2: tx_ready <= cyc[0];
      3: tx_ready <= ((cyc % 11) < 5);
      default: tx_ready <= 1'b0;
    endcase
  end

  always @(posedge clk) begin
    r1 <= tx_ready;
    r2 <= r1;
  end

  // beat monitor
  always @(negedge clk) begin
    if (mon_on) begin
      check(!tx_err, "R10 err low", {65'h0, tx_err}, 66'h0);
      if (tx_valid) check(r2 === 1'b1, "R6 valid needs ready two edges back", {65'h0, r2}, 66'h1);
      if (in_flight) check(!req_ready, "R9 busy blocks request", {65'h0, req_ready}, 66'h0);
      if (tx_valid) begin
        if (mon_idx >= exp_n) begin
          check(1'b0, "R8 extra beat", {tx_sop, tx_eop, tx_data}, 66'h0);
        end else begin
          check({tx_sop, tx_eop, tx_data} === {exp_sop[mon_idx], exp_eop[mon_idx], exp_data[mon_idx]},
                "R1 R2 R3 R4 R5 R8 beat content", {tx_sop, tx_eop, tx_data},
                {exp_sop[mon_idx], exp_eop[mon_idx], exp_data[mon_idx]});
          if (tx_eop) in_flight = 1'b0;
          mon_idx = mon_idx + 1;
        end
      end
    end
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; rdy_mode = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_hdr = '0;
    pl_push = 1'b0; pl_data = '0; tx_ready = 1'b1;
    in_flight = 1'b0; mon_on = 1'b0; exp_n = 0; mon_idx = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check(!tx_valid, "R12 valid low", {65'h0, tx_valid}, 66'h0);
    check(req_ready, "R12 req_ready high", {65'h0, req_ready}, 66'h1);
    check(!pl_full, "R12 pl_full low", {65'h0, pl_full}, 66'h0);
    check(!tx_err, "R12 err low", {65'h0, tx_err}, 66'h0);
    mon_on = 1'b1;

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      rdy_mode = int'(VECS[v].mode);
      build_exp(v + 1, VECS[v].skew, int'(VECS[v].len));
      fork
        push_all(v + 1, int'(VECS[v].len));
        issue_req(v + 1, VECS[v].skew, int'(VECS[v].len));
      join
      wait_done();
    end
    rdy_mode = 0;

    // R11 fill the buffer, push once more while full, then drain it
    build_exp(40, 1'b0, BUF_DEPTH);
    push_all(40, BUF_DEPTH);
    check(pl_full, "R11 full at depth", {65'h0, pl_full}, 66'h1);
    @(negedge clk);
    pl_push = 1'b1; pl_data = 32'hDEAD_BEEF;
    @(negedge clk);
    pl_push = 1'b0;
    issue_req(40, 1'b0, BUF_DEPTH);
    wait_done();
    check(!pl_full, "R11 empty after drain", {65'h0, pl_full}, 66'h0);

    // R11 the discarded word must not lead the next packet
    build_exp(41, 1'b0, 2);
    fork
      push_all(41, 2);
      issue_req(41, 1'b0, 2);
    join
    wait_done();

    // R6 R7 ready held low, then the two-cycle resume
    @(posedge clk); #1 rdy_mode = 4;
    repeat (3) @(negedge clk);
    build_exp(42, 1'b1, 3);
    fork
      push_all(42, 3);
      issue_req(42, 1'b1, 3);
    join
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!tx_valid, "R6 no beat while ready low", {65'h0, tx_valid}, 66'h0);
    end
    @(posedge clk); #1 rdy_mode = 0;
    @(negedge clk);
    @(negedge clk);
    check(!tx_valid, "R7 still waiting one cycle after ready", {65'h0, tx_valid}, 66'h0);
    @(negedge clk);
    check(tx_valid && tx_sop, "R7 resumed two cycles after ready", {64'h0, tx_valid, tx_sop}, 66'h3);
    wait_done();
    repeat (2) @(negedge clk);
    check(req_ready, "R9 ready for next request", {65'h0, req_ready}, 66'h1);
    check(mon_idx == exp_n, "R8 beat count", 66'(mon_idx), 66'(exp_n));

    finish_run();
  end

endmodule